// File: doc/BRIEF.md
# Parallel Configuration Data Pump

This block takes 32-bit configuration words from a simple valid/ready write port and plays them out on a passive-parallel configuration bus. The bus is either 16 or 32 bits wide and comes with its own data strobe. Each bus word is held for a programmable number of strobe cycles, so that a target doing decryption or decompression gets the extra strobes it needs per data word. Width and repeat count come from a mode-select code that is decoded inside the block.

In 16-bit operation an accepted word leaves as two half-words, low half first. A trailing partial word is marked with a byte count, and the block forces its unused upper bytes to zero before they reach the bus. Words are taken only while the transfer-enable input is high and the mode code is legal. The write port stays not-ready until every strobe of the current word has been issued.

Top module: `cfg_data_pump`

## Requirements
- R1: `mode_err` is high exactly for illegal mode codes: any code with bits [1:0] = 3, and any code of 16 or above.
- R2: `wr_ready` is low, and no word is taken, while `xfer_en` is low or the mode code is illegal.
- R3: With a 32-bit code (bit 3 set), the full word is on `bus_data` for 1, 4 or 8 strobe cycles when bits [1:0] are 0, 1 or 2.
- R4: With a 16-bit code (bit 3 clear), each half-word is shown for 1, 2 or 4 strobe cycles when bits [1:0] are 0, 1 or 2. The low half comes first, then the high half, and bus bits [31:16] are zero.
- R5: `wr_bytes` = 0 marks a full word. A value of 1, 2 or 3 keeps only that many low-order bytes and zeroes the rest.
- R6: After a word is accepted, `wr_ready` is low for exactly 2 × (strobes per word) clock cycles and returns on the cycle that follows.
- R7: Each strobe cycle lasts two clock cycles, `bus_dclk` low and then high, and `bus_data` does not change while `bus_dclk` is high. When no word is in flight, `bus_dclk` and `bus_data` are zero.
- R8: Mode-code bit 2 has no effect on width or repeat count.
- R9: `bus_wide` is high while a 32-bit-mode word is in flight and low for a 16-bit-mode word.
- R10: Changing `mode_sel`, `xfer_en` or `wr_data` while a word is in flight does not alter that word's bus output or its strobe count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_en | input | 1 | Transfer enable; gates acceptance of words |
| mode_sel | input | SEL_W (5) | Mode code selecting bus width and strobe ratio |
| wr_valid | input | 1 | Write-port word valid |
| wr_data | input | WORD_W (32) | Write-port word |
| wr_bytes | input | 2 | Valid byte count of the word, 0 meaning all four |
| wr_ready | output | 1 | Write-port ready |
| mode_err | output | 1 | Mode code is illegal |
| bus_data | output | WORD_W (32) | Configuration bus data |
| bus_dclk | output | 1 | Configuration data strobe |
| bus_wide | output | 1 | Word in flight uses the full bus width |

## Verification
The case that is hardest to reach from the ports is a mode or enable change that lands while a word is still being strobed out. It is reached by starting a long 32-bit ×8 word and then, on the third cycle after acceptance, switching the code to an illegal value and dropping the enable. The strobe count and the data still have to match the latched mode. Apart from that, the bench sweeps every legal code against four byte counts and two data patterns. It works out the expected strobe pattern and the slices from the code bits with arithmetic.

// File: rtl/cfg_pump_pkg.sv
package cfg_pump_pkg;

  // Ratio code: number of strobes per bus word is 2**ratio.
  localparam int RATIO_W = 2;
  localparam int CNT_W   = (1 << RATIO_W) - 1;

  typedef struct packed {
    logic               ok;
    logic               wide;
    logic [RATIO_W-1:0] ratio;
  } pump_mode_t;

  typedef enum logic [1:0] {
    KIND_PLAIN = 2'd0,
    KIND_ENC   = 2'd1,
    KIND_COMP  = 2'd2,
    KIND_BAD   = 2'd3
  } pump_kind_e;

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;

endmodule

// File: rtl/cfg_mode_decode.sv
module cfg_mode_decode
  import cfg_pump_pkg::*;
#(
  parameter int SEL_W = 5
) (
  input  logic [SEL_W-1:0] sel,
  output pump_mode_t       mode
);

  logic       hi_clear;
  pump_kind_e kind;

  generate
    if (SEL_W > 4) begin : g_hi_bits
      assign hi_clear = ~|sel[SEL_W-1:4];
    end else begin : g_no_hi_bits
      assign hi_clear = 1'b1;
    end
  endgenerate

  assign kind = pump_kind_e'(sel[1:0]);

  always_comb begin
    mode.ok   = hi_clear && (kind != KIND_BAD);
    mode.wide = sel[3];
    if (sel[3]) begin
      unique case (kind)
        KIND_PLAIN: mode.ratio = 2'd0;
        KIND_ENC:   mode.ratio = 2'd2;
        KIND_COMP:  mode.ratio = 2'd3;
        default:    mode.ratio = 2'd0;
      endcase
    end else begin
      unique case (kind)
        KIND_PLAIN: mode.ratio = 2'd0;
        KIND_ENC:   mode.ratio = 2'd1;
        KIND_COMP:  mode.ratio = 2'd2;
        default:    mode.ratio = 2'd0;
      endcase
    end
  end

endmodule

// File: rtl/cfg_byte_mask.sv
module cfg_byte_mask #(
  parameter int WORD_W = 32,
  localparam int LANES  = WORD_W / 8,
  localparam int BIDX_W = $clog2(LANES)
) (
  input  logic [WORD_W-1:0] din,
  input  logic [BIDX_W-1:0] nbytes,
  output logic [WORD_W-1:0] dout
);

  logic [BIDX_W:0] nb_ext;
  logic            full_word;

  assign nb_ext    = {1'b0, nbytes};
  assign full_word = (nbytes == '0);

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam logic [BIDX_W:0] LANE_IDX = (BIDX_W + 1)'(i);
      logic keep;
      assign keep = full_word || (LANE_IDX < nb_ext);
      assign dout[8*i +: 8] = keep ? din[8*i +: 8] : 8'h00;
    end
  endgenerate

endmodule

// File: rtl/cfg_lane_seq.sv
module cfg_lane_seq
  import cfg_pump_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int HALF_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  pump_mode_t        load_mode,
  output logic              busy,
  output logic [WORD_W-1:0] bus_data,
  output logic              bus_dclk,
  output logic              bus_wide
);

  logic               busy_q, busy_d;
  logic               phase_q, phase_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               slice_q, slice_d;
  logic               wide_q, wide_d;
  logic [RATIO_W-1:0] ratio_q, ratio_d;
  logic [WORD_W-1:0]  word_q;
  logic               word_ce;

  logic [CNT_W:0]     cnt_limit;
  logic               cnt_last;
  logic               slice_last;

  assign cnt_limit  = ((CNT_W + 1)'(1) << ratio_q) - (CNT_W + 1)'(1);
  assign cnt_last   = ({1'b0, cnt_q} == cnt_limit);
  assign slice_last = wide_q || slice_q;
  assign word_ce    = load && !busy_q;

  // Next-state process
  always_comb begin
    busy_d  = busy_q;
    phase_d = phase_q;
    cnt_d   = cnt_q;
    slice_d = slice_q;
    wide_d  = wide_q;
    ratio_d = ratio_q;
    if (!busy_q) begin
      if (load) begin
        busy_d  = 1'b1;
        phase_d = 1'b0;
        cnt_d   = '0;
        slice_d = 1'b0;
        wide_d  = load_mode.wide;
        ratio_d = load_mode.ratio;
      end
    end else begin
      phase_d = ~phase_q;
      if (phase_q) begin
        if (cnt_last) begin
          cnt_d = '0;
          if (slice_last) begin
            busy_d = 1'b0;
          end else begin
            slice_d = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      cnt_q   <= '0;
      slice_q <= 1'b0;
      wide_q  <= 1'b0;
      ratio_q <= '0;
    end else begin
      busy_q  <= busy_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      slice_q <= slice_d;
      wide_q  <= wide_d;
      ratio_q <= ratio_d;
    end
  end

  // Data holding register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_ce) begin
      word_q <= load_word;
    end
  end

  logic [HALF_W-1:0] half_sel;
  assign half_sel = slice_q ? word_q[WORD_W-1:HALF_W] : word_q[HALF_W-1:0];

  always_comb begin
    if (!busy_q) begin
      bus_data = '0;
    end else if (wide_q) begin
      bus_data = word_q;
    end else begin
      bus_data = {{(WORD_W - HALF_W){1'b0}}, half_sel};
    end
  end

  assign busy     = busy_q;
  assign bus_dclk = busy_q && phase_q;
  assign bus_wide = wide_q;

endmodule

// File: rtl/cfg_data_pump.sv
module cfg_data_pump
  import cfg_pump_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SEL_W  = 5,
  localparam int BIDX_W = $clog2(WORD_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_en,
  input  logic [SEL_W-1:0]  mode_sel,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [BIDX_W-1:0] wr_bytes,
  output logic              wr_ready,
  output logic              mode_err,
  output logic [WORD_W-1:0] bus_data,
  output logic              bus_dclk,
  output logic              bus_wide
);

  logic              rst_n_int;
  pump_mode_t        cur_mode;
  logic [WORD_W-1:0] masked_word;
  logic              seq_busy;
  logic              accept;

  cfg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  cfg_mode_decode #(.SEL_W(SEL_W)) u_dec (
    .sel  (mode_sel),
    .mode (cur_mode)
  );

  cfg_byte_mask #(.WORD_W(WORD_W)) u_mask (
    .din    (wr_data),
    .nbytes (wr_bytes),
    .dout   (masked_word)
  );

  assign wr_ready = rst_n_int && xfer_en && cur_mode.ok && !seq_busy;
  assign accept   = wr_valid && wr_ready;
  assign mode_err = !cur_mode.ok;

  cfg_lane_seq #(.WORD_W(WORD_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .load      (accept),
    .load_word (masked_word),
    .load_mode (cur_mode),
    .busy      (seq_busy),
    .bus_data  (bus_data),
    .bus_dclk  (bus_dclk),
    .bus_wide  (bus_wide)
  );

endmodule

// File: rtl/cfg_data_pump_chk.sv
module cfg_data_pump_chk #(
  parameter int WORD_W = 32,
  parameter int SEL_W  = 5,
  localparam int BIDX_W = $clog2(WORD_W / 8)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_en,
  input logic [SEL_W-1:0]  mode_sel,
  input logic              wr_valid,
  input logic [WORD_W-1:0] wr_data,
  input logic [BIDX_W-1:0] wr_bytes,
  input logic              wr_ready,
  input logic              mode_err,
  input logic [WORD_W-1:0] bus_data,
  input logic              bus_dclk,
  input logic              bus_wide
);

  assert_bad_kind_flagged_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel[1:0] == 2'b11) |-> mode_err);

  assert_ready_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (xfer_en && !mode_err));

  assert_accept_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !wr_ready);

  assert_dclk_alternates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dclk |=> !bus_dclk);

  assert_data_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dclk |-> $stable(bus_data));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!bus_dclk && (bus_data == '0)));

  assert_narrow_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wide |-> (bus_data[WORD_W-1:WORD_W/2] == '0));

endmodule

bind cfg_data_pump cfg_data_pump_chk #(.WORD_W(WORD_W), .SEL_W(SEL_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .xfer_en  (xfer_en),
  .mode_sel (mode_sel),
  .wr_valid (wr_valid),
  .wr_data  (wr_data),
  .wr_bytes (wr_bytes),
  .wr_ready (wr_ready),
  .mode_err (mode_err),
  .bus_data (bus_data),
  .bus_dclk (bus_dclk),
  .bus_wide (bus_wide)
);

// File: tb/cfg_data_pump_tb_top.sv
module cfg_data_pump_tb_top;

  logic        clk;
  logic        rst_n;
  logic        xfer_en;
  logic [4:0]  mode_sel;
  logic        wr_valid;
  logic [31:0] wr_data;
  logic [1:0]  wr_bytes;
  logic        wr_ready;
  logic        mode_err;
  logic [31:0] bus_data;
  logic        bus_dclk;
  logic        bus_wide;

  int n_chk;
  int n_fail;
  int cyc;

  cfg_data_pump dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .xfer_en  (xfer_en),
    .mode_sel (mode_sel),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .wr_bytes (wr_bytes),
    .wr_ready (wr_ready),
    .mode_err (mode_err),
    .bus_data (bus_data),
    .bus_dclk (bus_dclk),
    .bus_wide (bus_wide)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Send one word and follow its strobes for the full expected window.
  task automatic run_word(input logic [4:0] sel, input logic [31:0] d,
                          input logic [1:0] nb, input bit disturb);
    bit          w;
    int          lg, r, n, exp_cyc, hi, idx;
    int          bad_phase, bad_ready, bad_wide, bad_data;
    logic [31:0] m, e;
    logic        end_ready;
    string       tag;
    w   = sel[3];
    lg  = w ? ((sel[1:0] == 2'd0) ? 0 : int'(sel[1:0]) + 1) : int'(sel[1:0]);
    r   = 1 << lg;
    n   = w ? 1 : 2;
    exp_cyc = 2 * r * n;
    m   = (nb == 2'd0) ? d : (d & ((32'h1 << (8 * nb)) - 32'h1));
    hi = 0; bad_phase = 0; bad_ready = 0; bad_wide = 0; bad_data = 0;
    end_ready = 1'b0;
    @(negedge clk);
    mode_sel = sel; xfer_en = 1'b1; wr_data = d; wr_bytes = nb; wr_valid = 1'b1;
    #1;
    check(wr_ready === 1'b1, "R2 ready with enable and legal code", 32'(wr_ready), 32'd1);
    @(negedge clk);
    wr_valid = 1'b0;
    wr_data  = ~d;        // R10: input changes after acceptance
    wr_bytes = nb + 2'd1;
    for (int k = 1; k <= exp_cyc + 2; k++) begin
      if (k > 1) @(negedge clk);
      if (disturb && k == 3) begin
        mode_sel = 5'h13;
        xfer_en  = 1'b0;
      end
      #1;
      if (k <= exp_cyc) begin
        if (bus_dclk !== ((k % 2) == 0)) bad_phase++;
        if (wr_ready !== 1'b0) bad_ready++;
        if (bus_wide !== w) bad_wide++;
        if (bus_dclk === 1'b1) begin
          idx = hi / r;
          e = w ? m : ((m >> (16 * idx)) & 32'h0000_FFFF);
          if (bus_data !== e) bad_data++;
          hi++;
        end
      end else begin
        if (bus_dclk !== 1'b0) bad_phase++;
        if (bus_data !== 32'h0) bad_data++;
        if (k == exp_cyc + 1) end_ready = wr_ready;
      end
    end
    tag = disturb ? "R10 strobe count" : (sel[2] ? "R8 strobe count" :
          (w ? "R3 strobe count" : "R4 strobe count"));
    check(hi == r * n, tag, 32'(hi), 32'(r * n));
    tag = disturb ? "R10 data" : ((nb != 2'd0) ? "R5 masked data" :
          (w ? "R3 data" : "R4 half-word data"));
    check(bad_data == 0, tag, 32'(bad_data), 32'd0);
    check(bad_phase == 0, "R7 strobe phasing", 32'(bad_phase), 32'd0);
    check(bad_ready == 0, "R6 ready low while busy", 32'(bad_ready), 32'd0);
    check(bad_wide == 0, "R9 width flag", 32'(bad_wide), 32'd0);
    if (disturb) begin
      check(end_ready === 1'b0, "R10 ready stays low after enable drop",
            32'(end_ready), 32'd0);
      check(mode_err === 1'b1, "R1 error for code 0x13", 32'(mode_err), 32'd1);
      xfer_en = 1'b1;
    end else begin
      check(end_ready === 1'b1, "R6 ready returns after last strobe",
            32'(end_ready), 32'd1);
    end
  endtask

  task automatic hold_refused(input string tag);
    int seen_ready, seen_dclk;
    seen_ready = 0; seen_dclk = 0;
    wr_valid = 1'b1;
    wr_data  = 32'hDEAD_BEEF;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      #1;
      if (wr_ready !== 1'b0) seen_ready++;
      if (bus_dclk !== 1'b0) seen_dclk++;
    end
    wr_valid = 1'b0;
    check(seen_ready == 0, tag, 32'(seen_ready), 32'd0);
    check(seen_dclk == 0, tag, 32'(seen_dclk), 32'd0);
  endtask

  initial begin
    bit          exp_err;
    logic [31:0] pats [2];
    n_chk = 0; n_fail = 0; cyc = 0;
    rst_n = 1'b0; xfer_en = 1'b0; mode_sel = 5'd0;
    wr_valid = 1'b0; wr_data = 32'h0; wr_bytes = 2'd0;
    pats[0] = 32'hA5C3_1E96;
    pats[1] = 32'h0F1E_2D3C;
    repeat (3) @(negedge clk);
    #1;
    check(wr_ready === 1'b0, "R2 ready low in reset", 32'(wr_ready), 32'd0);
    check(bus_dclk === 1'b0, "R7 strobe low in reset", 32'(bus_dclk), 32'd0);
    check(bus_data === 32'h0, "R7 bus zero in reset", bus_data, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(wr_ready === 1'b0, "R2 ready low with enable off", 32'(wr_ready), 32'd0);

    // R1: sweep all mode codes
    for (int c = 0; c < 32; c++) begin
      @(negedge clk);
      mode_sel = 5'(c);
      #1;
      exp_err = (c >= 16) || ((c % 4) == 3);
      check(mode_err === exp_err, "R1 mode code legality", 32'(mode_err), 32'(exp_err));
    end

    // R2: refusal with enable low, then with an illegal code
    mode_sel = 5'h08; xfer_en = 1'b0;
    hold_refused("R2 refused with enable low");
    xfer_en = 1'b1; mode_sel = 5'h07;
    hold_refused("R2 refused with illegal code");
    mode_sel = 5'h1C;
    hold_refused("R2 refused with code above 15");

    // R3, R4, R5, R8: every legal code, all byte counts, two patterns
    for (int c = 0; c < 16; c++) begin
      if ((c % 4) != 3) begin
        for (int b = 0; b < 4; b++) begin
          for (int p = 0; p < 2; p++) begin
            run_word(5'(c), pats[p], 2'(b), 1'b0);
          end
        end
      end
    end

    // R10: mode and enable disturbed mid-word on a long 32-bit x8 word
    run_word(5'h0A, 32'h1234_5678, 2'd0, 1'b1);
    run_word(5'h01, 32'h8765_4321, 2'd2, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule